// File: doc/BRIEF.md
# Configuration Frame Scrub and Repair Controller

This block walks through the configuration frames of a device one at a time. For each frame it collects the readback words into a local buffer. It then waits for the error-detection result that arrives once the frame has been read. An external checker computes a 12-bit SECDED syndrome and supplies it with an error flag and a one-cycle valid strobe. The controller only acts on that result.

If the frame is clean, the controller moves its frame address on and reads the next frame. If an error is flagged, the controller stops readback and keeps a copy of the syndrome. It then decodes the syndrome to pick a repair:
- A correctable single-bit error, where bit 11 is set and the position is inside the frame, is fixed by inverting that one bit in the buffer.
- Any other flagged error makes the controller request the original frame from external storage and load it into the buffer.

In both cases the buffered frame is then streamed out as write-back words to the frame address it came from. Readback then resumes at the next frame address. Computing the syndrome and the physical configuration port are outside this block.

Top module: `frame_scrubber`

## Requirements
- R1: After a synchronous active-low reset, `frame_addr` is 0, `rd_en` is 1, `wb_valid` is 0 and `reload_req` is 0.
- R2: A frame is 41 words of 32 bits, and buffer word k holds frame bits 32k to 32k+31. While `rd_en` is 1, each cycle with `rb_valid` high stores the next word, from word 0 up to word 40. After word 40 the block waits for `syn_valid`. If `syn_valid` arrives with `syn_err` = 0, there is no write-back, and `frame_addr` advances by one in the cycle after the strobe.
- R3: If `syn_valid` arrives with `syn_err` = 1 and `syn_code[11]` = 1, bits 10:0 give a bit index p. When p < 1312, the block emits 41 write-back words in order from word 0. Word p/32 has bit p mod 32 inverted, and all other words are as read. `wb_addr` equals the frame address that was read.
- R4: If `syn_valid` arrives with `syn_err` = 1 and `syn_code[11]` = 0, the block raises `reload_req`. It stores 41 words delivered on `reload_word` with `reload_valid`, lowers `reload_req`, and writes those words back unchanged. `reload_req` and `wb_valid` are never high together.
- R5: A flagged syndrome with `syn_code[11]` = 1 and bit index 1312 or above is handled as a full-frame reload, as in R4.
- R6: From the error strobe until the last write-back word, `rd_en` is 0. Any `rb_valid` words offered in that time do not change the frame that is written back.
- R7: In the cycle after the last write-back word, `rd_en` is 1 again and `frame_addr` equals the repaired frame's address plus one.
- R8: `frame_addr` counts 0 to NUM_FRAMES-1, which is 7 with the default of 8, and then wraps to 0.
- R9: A `syn_valid` strobe that comes while frame words are still being read is ignored: it causes no write-back, no reload request and no address change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | output | 1 | Readback enabled; words are accepted only while high |
| frame_addr | output | 3 | Address of the frame being read |
| rb_valid | input | 1 | Readback word strobe |
| rb_word | input | 32 | Readback word |
| syn_valid | input | 1 | One-cycle strobe marking a syndrome result |
| syn_err | input | 1 | Error flag that goes with the syndrome |
| syn_code | input | 12 | Syndrome: bit 11 marks a single error, bits 10:0 give the position |
| reload_req | output | 1 | Request for the original copy of the frame |
| reload_valid | input | 1 | Original-copy word strobe |
| reload_word | input | 32 | Original-copy word |
| wb_valid | output | 1 | Write-back word valid |
| wb_word | output | 32 | Write-back word |
| wb_addr | output | 3 | Destination frame of the write-back |

## Verification
The assertions check on every cycle that write-back and readback are never enabled together, that a reload request never overlaps write-back, and that the address stays constant during a write-back burst. They also check that the address stays in range and steps by exactly one, with wrap, when a burst ends. Only the bench scenarios can show the data behaviour:
- the single located bit being inverted, at an interior position and at the last bit of the frame;
- reloaded words passing through unchanged;
- an out-of-range index being sent to reload;
- words offered during a halt being dropped;
- a strobe arriving mid-frame being ignored.

// File: rtl/scrub_pkg.sv
// Shared types of the frame scrub controller.
// Assumes: no parameters live here; widths come from the modules.
package scrub_pkg;
    typedef enum logic [2:0] {
        ST_READ,
        ST_WAIT,
        ST_DECIDE,
        ST_RELOAD,
        ST_WRITE
    } scrub_state_t;

    typedef enum logic [1:0] {
        FIX_NONE,
        FIX_BIT,
        FIX_FRAME
    } fix_kind_t;
endpackage

// File: rtl/syndrome_decode.sv
// Classifies a latched syndrome into a repair action.
// Assumes: WORD_W is a power of two, and the top bit of the code marks a
// single error whose position is held in the bits below it.
module syndrome_decode
    import scrub_pkg::*;
#(
    parameter int SYN_W       = 12,
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 41
) (
    input  logic                           err,
    input  logic [SYN_W-1:0]               code,
    output fix_kind_t                      kind,
    output logic [$clog2(FRAME_WORDS)-1:0] word_idx,
    output logic [$clog2(WORD_W)-1:0]      bit_off
);
    localparam int IDX_W  = SYN_W - 1;
    localparam int BOFF_W = $clog2(WORD_W);
    localparam int WIDX_W = $clog2(FRAME_WORDS);
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(WORD_W * FRAME_WORDS);

    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] wsel;

    assign pos  = code[IDX_W-1:0];
    assign wsel = pos >> BOFF_W;

    // Purpose: choose a bit flip only for an in-frame located single error.
    always_comb begin
        if (!err)
            kind = FIX_NONE;
        else if (code[SYN_W-1] && (pos < LIMIT))
            kind = FIX_BIT;
        else
            kind = FIX_FRAME;
    end

    assign word_idx = wsel[WIDX_W-1:0];
    assign bit_off  = pos[BOFF_W-1:0];
endmodule

// File: rtl/frame_buffer.sv
// Holds one frame as FRAME_WORDS words of WORD_W bits.
// Assumes: a write and a flip never fall in the same cycle (the write wins),
// and the indices are in range.
module frame_buffer #(
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 41
) (
    input  logic                           clk,
    input  logic                           wr_en,
    input  logic [$clog2(FRAME_WORDS)-1:0] wr_idx,
    input  logic [WORD_W-1:0]              wr_data,
    input  logic                           flip_en,
    input  logic [$clog2(FRAME_WORDS)-1:0] flip_word,
    input  logic [$clog2(WORD_W)-1:0]      flip_bit,
    input  logic [$clog2(FRAME_WORDS)-1:0] rd_idx,
    output logic [WORD_W-1:0]              rd_data
);
    logic [WORD_W-1:0] mem [FRAME_WORDS];

    // Purpose: store incoming words, or invert a single located bit.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_data;
        else if (flip_en)
            mem[flip_word][flip_bit] <= ~mem[flip_word][flip_bit];
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/frame_addr_gen.sv
// Frame address counter that steps once per finished frame and wraps.
// Assumes: NUM_FRAMES >= 2.
module frame_addr_gen #(
    parameter int NUM_FRAMES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          step,
    output logic [$clog2(NUM_FRAMES)-1:0] addr
);
    localparam int ADDR_W = $clog2(NUM_FRAMES);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_FRAMES - 1);

    // Purpose: advance the address, returning to zero after the last frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (step)
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
    end

    assert_addr_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= LAST);

    assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(addr));
endmodule

// File: rtl/frame_scrubber.sv
// Frame scrub and repair controller: reads a frame into the buffer, waits for
// its syndrome, and then advances, flips one bit and writes back, or reloads
// and writes back.
// Assumes: syn_valid is a one-cycle strobe that comes after the last frame
// word; reload words come only while reload_req is high.
module frame_scrubber
    import scrub_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int FRAME_WORDS = 41,
    parameter int SYN_W       = 12,
    parameter int NUM_FRAMES  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          rd_en,
    output logic [$clog2(NUM_FRAMES)-1:0] frame_addr,
    input  logic                          rb_valid,
    input  logic [WORD_W-1:0]             rb_word,
    input  logic                          syn_valid,
    input  logic                          syn_err,
    input  logic [SYN_W-1:0]              syn_code,
    output logic                          reload_req,
    input  logic                          reload_valid,
    input  logic [WORD_W-1:0]             reload_word,
    output logic                          wb_valid,
    output logic [WORD_W-1:0]             wb_word,
    output logic [$clog2(NUM_FRAMES)-1:0] wb_addr
);
    localparam int WIDX_W = $clog2(FRAME_WORDS);
    localparam int BOFF_W = $clog2(WORD_W);
    localparam int ADDR_W = $clog2(NUM_FRAMES);
    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(FRAME_WORDS - 1);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(NUM_FRAMES - 1);

    scrub_state_t      state;
    logic [WIDX_W-1:0] cnt;
    logic [SYN_W-1:0]  syn_q;
    logic              err_q;
    fix_kind_t         kind;
    logic [WIDX_W-1:0] fix_word;
    logic [BOFF_W-1:0] fix_bit;
    logic              step;
    logic              buf_wr;
    logic [WORD_W-1:0] buf_wdata;
    logic              buf_flip;
    logic              last_cnt;

    syndrome_decode #(
        .SYN_W(SYN_W), .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)
    ) u_dec (
        .err(err_q), .code(syn_q), .kind(kind),
        .word_idx(fix_word), .bit_off(fix_bit)
    );

    frame_buffer #(
        .WORD_W(WORD_W), .FRAME_WORDS(FRAME_WORDS)
    ) u_buf (
        .clk(clk), .wr_en(buf_wr), .wr_idx(cnt), .wr_data(buf_wdata),
        .flip_en(buf_flip), .flip_word(fix_word), .flip_bit(fix_bit),
        .rd_idx(cnt), .rd_data(wb_word)
    );

    frame_addr_gen #(
        .NUM_FRAMES(NUM_FRAMES)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .step(step), .addr(frame_addr)
    );

    assign last_cnt   = (cnt == LAST_W);
    assign rd_en      = (state == ST_READ);
    assign reload_req = (state == ST_RELOAD);
    assign wb_valid   = (state == ST_WRITE);
    assign wb_addr    = frame_addr;

    // Purpose: route readback or original-copy words into the buffer.
    always_comb begin
        buf_wr    = 1'b0;
        buf_wdata = rb_word;
        if (state == ST_READ && rb_valid) begin
            buf_wr = 1'b1;
        end else if (state == ST_RELOAD && reload_valid) begin
            buf_wr    = 1'b1;
            buf_wdata = reload_word;
        end
    end

    assign buf_flip = (state == ST_DECIDE) && (kind == FIX_BIT);

    // Purpose: move the address on after a clean frame or a finished write-back.
    assign step = (state == ST_WAIT && syn_valid && !syn_err) ||
                  (state == ST_WRITE && last_cnt);

    // Purpose: sequence read, wait, decide, reload and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READ;
            cnt   <= '0;
            syn_q <= '0;
            err_q <= 1'b0;
        end else begin
            case (state)
                ST_READ: if (rb_valid) begin
                    cnt <= last_cnt ? '0 : cnt + 1'b1;
                    if (last_cnt) state <= ST_WAIT;
                end
                ST_WAIT: if (syn_valid) begin
                    if (syn_err) begin
                        syn_q <= syn_code;
                        err_q <= 1'b1;
                        state <= ST_DECIDE;
                    end else begin
                        state <= ST_READ;
                    end
                end
                ST_DECIDE: state <= (kind == FIX_BIT) ? ST_WRITE : ST_RELOAD;
                ST_RELOAD: if (reload_valid) begin
                    cnt <= last_cnt ? '0 : cnt + 1'b1;
                    if (last_cnt) state <= ST_WRITE;
                end
                ST_WRITE: begin
                    cnt <= last_cnt ? '0 : cnt + 1'b1;
                    if (last_cnt) begin
                        state <= ST_READ;
                        err_q <= 1'b0;
                    end
                end
                default: state <= ST_READ;
            endcase
        end
    end

    assert_halt_during_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> !rd_en);

    assert_reload_not_wb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(reload_req && wb_valid));

    assert_wb_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && $past(wb_valid)) |-> $stable(wb_addr));

    assert_resume_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_valid) |-> (rd_en &&
            frame_addr == (($past(frame_addr) == LAST_A) ? '0 : $past(frame_addr) + 1'b1)));
endmodule

// File: tb/sim_frame_scrubber.sv
module sim_frame_scrubber;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 41;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en;
    logic [2:0]  frame_addr;
    logic        rb_valid = 1'b0;
    logic [31:0] rb_word = '0;
    logic        syn_valid = 1'b0;
    logic        syn_err = 1'b0;
    logic [11:0] syn_code = '0;
    logic        reload_req;
    logic        reload_valid = 1'b0;
    logic [31:0] reload_word = '0;
    logic        wb_valid;
    logic [31:0] wb_word;
    logic [2:0]  wb_addr;

    int checks = 0;
    int errors = 0;
    int wb_cycles = 0;
    int req_cycles = 0;

    frame_scrubber u0 (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .frame_addr(frame_addr),
        .rb_valid(rb_valid), .rb_word(rb_word), .syn_valid(syn_valid),
        .syn_err(syn_err), .syn_code(syn_code), .reload_req(reload_req),
        .reload_valid(reload_valid), .reload_word(reload_word),
        .wb_valid(wb_valid), .wb_word(wb_word), .wb_addr(wb_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (wb_valid) wb_cycles++;
        if (reload_req) req_cycles++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fword(input int a, input int i);
        return (32'h9E3779B9 * (i + 1)) ^ (32'(a) << 24) ^ 32'(i);
    endfunction

    // Drive one frame of words; optionally pulse a syndrome strobe mid-frame.
    task automatic send_frame(input int a, input bit stray);
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            rb_valid = 1'b1;
            rb_word  = fword(a, i);
            syn_valid = stray && (i == 10);
            syn_err   = stray && (i == 10);
            syn_code  = (stray && i == 10) ? 12'h805 : 12'h000;
        end
        @(negedge clk);
        rb_valid = 1'b0;
        syn_valid = 1'b0;
        syn_err = 1'b0;
    endtask

    task automatic send_syn(input bit err, input logic [11:0] code);
        syn_valid = 1'b1;
        syn_err   = err;
        syn_code  = code;
        @(negedge clk);
        syn_valid = 1'b0;
        syn_err   = 1'b0;
    endtask

    // Collect the write-back burst and compare it with the expected words.
    task automatic collect_wb(input string req, input int a, input logic [31:0] exp [NW]);
        int got = 0;
        int guard = 0;
        int bad = 0;
        while (got < NW && guard < 400) begin
            if (wb_valid) begin
                if (wb_word !== exp[got] || wb_addr !== 3'(a) || rd_en !== 1'b0) begin
                    if (bad == 0)
                        $display("FAIL %s: word %0d actual %h expected %h addr %0d",
                                 req, got, wb_word, exp[got], wb_addr);
                    bad++;
                end
                got++;
            end
            if (got < NW) @(negedge clk);
            guard++;
        end
        checks++;
        if (bad != 0 || got != NW) begin
            errors++;
            if (got != NW) $display("FAIL %s: actual %0d words expected %0d", req, got, NW);
        end
    endtask

    task automatic check_resume(input string req, input int a);
        rb_valid = 1'b0;
        @(negedge clk);
        check(req, {31'd0, rd_en}, 32'd1);
        check(req, {29'd0, frame_addr}, 32'((a + 1) % 8));
        check(req, {31'd0, wb_valid}, 32'd0);
    endtask

    task automatic t_reset;
        check("R1", {29'd0, frame_addr}, 32'd0);
        check("R1", {31'd0, rd_en}, 32'd1);
        check("R1", {31'd0, wb_valid}, 32'd0);
        check("R1", {31'd0, reload_req}, 32'd0);
    endtask

    task automatic t_clean(input int a, input string req);
        int w0 = wb_cycles;
        send_frame(a, 1'b0);
        send_syn(1'b0, 12'h000);
        check(req, {29'd0, frame_addr}, 32'((a + 1) % 8));
        check(req, {31'd0, rd_en}, 32'd1);
        check(req, 32'(wb_cycles - w0), 32'd0);
    endtask

    task automatic t_stray(input int a);
        int w0 = wb_cycles;
        int r0 = req_cycles;
        send_frame(a, 1'b1);
        check("R9", {29'd0, frame_addr}, 32'(a));
        send_syn(1'b0, 12'h000);
        check("R9", {29'd0, frame_addr}, 32'((a + 1) % 8));
        check("R9", 32'(wb_cycles - w0), 32'd0);
        check("R9", 32'(req_cycles - r0), 32'd0);
    endtask

    task automatic t_single(input int a, input int pos, input string req);
        logic [31:0] exp [NW];
        for (int i = 0; i < NW; i++) exp[i] = fword(a, i);
        exp[pos / 32][pos % 32] = ~exp[pos / 32][pos % 32];
        send_frame(a, 1'b0);
        send_syn(1'b1, 12'h800 | 12'(pos));
        check("R6", {31'd0, rd_en}, 32'd0);
        rb_valid = 1'b1;
        rb_word  = 32'hDEADBEEF;
        collect_wb(req, a, exp);
        check_resume("R7", a);
    endtask

    task automatic t_reload(input int a, input logic [11:0] code, input string req);
        logic [31:0] exp [NW];
        int guard = 0;
        for (int i = 0; i < NW; i++) exp[i] = ~fword(a, i) ^ 32'h00FF00FF;
        send_frame(a, 1'b0);
        send_syn(1'b1, code);
        rb_valid = 1'b1;
        rb_word  = 32'h0BADF00D;
        while (!reload_req && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        check(req, {31'd0, reload_req}, 32'd1);
        check("R6", {31'd0, rd_en}, 32'd0);
        for (int i = 0; i < NW; i++) begin
            reload_valid = 1'b1;
            reload_word  = exp[i];
            @(negedge clk);
        end
        reload_valid = 1'b0;
        check(req, {31'd0, reload_req}, 32'd0);
        collect_wb(req, a, exp);
        check_resume("R7", a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean(0, "R2");
        t_stray(1);
        t_single(2, 1000, "R3");
        t_single(3, 1311, "R3");
        t_reload(4, 12'h013, "R4");
        t_reload(5, 12'h800 | 12'd1312, "R5");
        t_clean(6, "R2");
        t_clean(7, "R8");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule